// File: doc/BRIEF.md
# Flash Command Sequencer with Unlock Decoding

This block is the command front end of a parallel NOR flash macro. It sits behind the bus interface, which has already captured each bus write as an address and a data word. The block tracks multi-write command sequences that each begin with a two-write unlock prefix. It decides which mode the array port is in and issues single-cycle program requests to an external program/erase engine. While auto-select mode is active, it also replaces array read data with identification and protection codes.

A command is accepted only after the prefix 0xAA at word address 0x555, then 0x55 at 0x2AA, then a command byte at 0x555. Any other write returns the block to read mode, so a stray write cannot reach the program engine. The command byte selects auto-select, program, or unlock-bypass mode. In unlock-bypass mode a program takes two writes instead of four. When the engine reports busy, writes are dropped, with one exception: the one-write read/reset command still resets the block. A program aimed at a protected block is discarded and sets a sticky error flag.

States: `S_READ` (array reads), `S_UNL1` (0xAA seen), `S_UNL2` (prefix complete), `S_AUTOSEL` (code reads), `S_PRG_WAIT` (waiting for the program address/data), `S_BYP` (bypass idle), `S_BYP_PRG` (bypass program, waiting for address/data), `S_BYP_RST` (bypass exit, waiting for 0x00). Transitions: `READ/AUTOSEL -(AA@555)-> UNL1 -(55@2AA)-> UNL2`; `UNL2 -(90@555)-> AUTOSEL`, `-(A0@555)-> PRG_WAIT`, `-(20@555)-> BYP`; `PRG_WAIT -(any)-> READ`; `BYP -(A0)-> BYP_PRG -(any)-> BYP`; `BYP -(90)-> BYP_RST -(00)-> READ`, `BYP_RST -(other)-> BYP`. Any F0 write in `READ/UNL1/UNL2/AUTOSEL` goes to `READ`. Any other write that breaks the sequence also goes to `READ`.

Top module: `flashcmd_seq`

## Requirements
- R1: After reset `mode` is 2'b00 (read), `bypass`, `prog_req` and `err` are 0. In read mode `rd_data` equals `array_data`. The `mode` encoding is 00 read, 01 auto-select, 10 unlock-bypass, and 11 never appears.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 put `mode` at 01 in the cycle after the third write. The block stays in auto-select through any number of reads, until the next write.
- R3: In auto-select, reads with rd_addr[1:0]=00 return 0x0020, with 01 return the `DEV_ID` parameter, and with 11 return 0x0000.
- R4: In auto-select, a read with rd_addr[1:0]=10 returns 0x0001 if `blk_prot[rd_addr[15:12]]` is 1, else 0x0000.
- R5: After the prefix and 0xA0@0x555, the next write makes `prog_req` high for exactly one cycle, starting in the cycle after that write. `prog_addr`/`prog_data` carry that write's address and data, and `mode` returns to 00.
- R6: The prefix followed by 0x20@0x555 sets `mode` to 10 and `bypass` to 1. In this mode, writes other than 0xA0 or 0x90 are ignored (0xF0 included), and reads return `array_data`.
- R7: In unlock-bypass, a 0xA0 write to any address followed by an address/data write issues a program request as in R5, and the block stays in unlock-bypass.
- R8: In unlock-bypass, 0x90 followed by 0x00 returns `mode` to 00. 0x90 followed by any other byte leaves the block in unlock-bypass.
- R9: A write whose low byte is 0xF0, at any address, in read, auto-select or either unlock step, returns `mode` to 00 and clears `err`. This holds even while `busy` is high.
- R10: A write that does not continue a valid sequence returns `mode` to 00, and the write that follows it is decoded from the start.
- R11: Decoding compares only wr_addr[10:0] and wr_data[7:0]. Other bits do not change the result.
- R12: A program write to a block whose `blk_prot` bit (index wr_addr[15:12]) is 1 raises no `prog_req` and sets `err`, which stays set until an F0 write or a reset.
- R13: While `busy` is high, writes other than the F0 of R9 cause no state change and no `prog_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| wr_valid | input | 1 | One-cycle strobe for a latched bus write |
| wr_addr | input | ADDR_W | Word address of the bus write |
| wr_data | input | DATA_W | Data of the bus write |
| busy | input | 1 | Program/erase engine is busy |
| blk_prot | input | NBLK | Protection bit per block |
| rd_addr | input | ADDR_W | Word address of the bus read |
| array_data | input | DATA_W | Data read from the array |
| rd_data | output | DATA_W | Read data after the code mux |
| mode | output | 2 | Current mode (00 read, 01 auto-select, 10 bypass) |
| bypass | output | 1 | Unlock-bypass mode active |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | DATA_W | Program data |
| err | output | 1 | Sticky protected-program error |

## Verification
The decoder is exercised with several kinds of write sequence. There are clean prefixes ending in each command byte. There are prefixes with a wrong second address or an unknown command byte. There are prefixes with high address and data bits set: these should match, and they separate the 11-bit compare from a full-width compare. There are program sequences aimed at protected and unprotected blocks. Bypass traffic is mixed with F0 and AA writes, which must be ignored there but not in read mode. A write held off by busy, followed by a second write while no longer busy, shows that the wait state was kept rather than dropped. Auto-select reads cover every A1/A0 code and both protected and unprotected blocks.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

    typedef enum logic [1:0] {
        MODE_READ    = 2'd0,
        MODE_AUTOSEL = 2'd1,
        MODE_BYPASS  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_AUTOSEL,
        S_PRG_WAIT,
        S_BYP,
        S_BYP_PRG,
        S_BYP_RST
    } state_e;

    localparam int          CMP_W      = 11;
    localparam logic [10:0] ADR_FIRST  = 11'h555;
    localparam logic [10:0] ADR_SECOND = 11'h2AA;

    localparam logic [7:0] CMD_UNLK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B = 8'h55;
    localparam logic [7:0] CMD_IDREAD = 8'h90;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_BYPASS = 8'h20;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_BYPEND = 8'h00;

    localparam logic [15:0] MFR_CODE  = 16'h0020;

endpackage

// File: rtl/flashcmd_decode.sv
module flashcmd_decode
    import flashcmd_pkg::*;
#(
    parameter int NBLK  = 16,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic [CMP_W-1:0] cmp_addr,
    input  logic [7:0]       cmd_byte,
    input  logic [BLK_W-1:0] blk_idx,
    input  logic [NBLK-1:0]  blk_prot,
    output logic             at_first,
    output logic             at_second,
    output logic             is_reset,
    output logic             tgt_prot
);

    always_comb begin
        at_first  = (cmp_addr == ADR_FIRST);
        at_second = (cmp_addr == ADR_SECOND);
        is_reset  = (cmd_byte == CMD_RESET);
        tgt_prot  = blk_prot[blk_idx];
    end

endmodule

// File: rtl/flashcmd_fsm.sv
module flashcmd_fsm
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              at_first,
    input  logic              at_second,
    input  logic              is_reset,
    input  logic              tgt_prot,
    output logic [1:0]        mode,
    output logic              bypass,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              err
);

    state_e     cur, nxt;
    logic       fire;
    logic       clr_err;
    logic [7:0] cmd;

    assign cmd = wr_data[7:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= S_READ;
        else        cur <= nxt;
    end

    // next state and actions
    always_comb begin
        nxt     = cur;
        fire    = 1'b0;
        clr_err = 1'b0;
        if (wr_valid) begin
            unique case (cur)
                S_READ, S_AUTOSEL: begin
                    if (is_reset) begin
                        nxt     = S_READ;
                        clr_err = 1'b1;
                    end else if (!busy) begin
                        nxt = (at_first && cmd == CMD_UNLK_A) ? S_UNL1 : S_READ;
                    end
                end
                S_UNL1: begin
                    if (is_reset) begin
                        nxt     = S_READ;
                        clr_err = 1'b1;
                    end else if (!busy) begin
                        nxt = (at_second && cmd == CMD_UNLK_B) ? S_UNL2 : S_READ;
                    end
                end
                S_UNL2: begin
                    if (is_reset) begin
                        nxt     = S_READ;
                        clr_err = 1'b1;
                    end else if (!busy) begin
                        nxt = S_READ;
                        if (at_first) begin
                            case (cmd)
                                CMD_IDREAD: nxt = S_AUTOSEL;
                                CMD_PROG:   nxt = S_PRG_WAIT;
                                CMD_BYPASS: nxt = S_BYP;
                                default:    nxt = S_READ;
                            endcase
                        end
                    end
                end
                S_PRG_WAIT: begin
                    if (!busy) begin
                        fire = 1'b1;
                        nxt  = S_READ;
                    end
                end
                S_BYP: begin
                    if (!busy) begin
                        if (cmd == CMD_PROG)        nxt = S_BYP_PRG;
                        else if (cmd == CMD_IDREAD) nxt = S_BYP_RST;
                    end
                end
                S_BYP_PRG: begin
                    if (!busy) begin
                        fire = 1'b1;
                        nxt  = S_BYP;
                    end
                end
                S_BYP_RST: begin
                    if (!busy) begin
                        nxt = (cmd == CMD_BYPEND) ? S_READ : S_BYP;
                    end
                end
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_req  <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
            err       <= 1'b0;
        end else begin
            prog_req <= fire && !tgt_prot;
            if (fire && !tgt_prot) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (clr_err)              err <= 1'b0;
            else if (fire && tgt_prot) err <= 1'b1;
        end
    end

    // mode decode
    always_comb begin
        unique case (cur)
            S_AUTOSEL:                   mode = MODE_AUTOSEL;
            S_BYP, S_BYP_PRG, S_BYP_RST: mode = MODE_BYPASS;
            default:                     mode = MODE_READ;
        endcase
        bypass = (mode == MODE_BYPASS);
    end

endmodule

// File: rtl/flashcmd_rdmux.sv
module flashcmd_rdmux
    import flashcmd_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 16,
    parameter int          NBLK   = 16,
    parameter logic [15:0] DEV_ID = 16'h00D0,
    localparam int         BLK_W  = $clog2(NBLK)
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    input  logic [NBLK-1:0]   blk_prot,
    output logic [DATA_W-1:0] rd_data
);

    logic unused_rd_bits;
    logic prot_bit;

    assign unused_rd_bits = ^rd_addr[ADDR_W-BLK_W-1:2];
    assign prot_bit       = blk_prot[rd_addr[ADDR_W-1 -: BLK_W]];

    always_comb begin
        rd_data = array_data;
        if (mode == MODE_AUTOSEL) begin
            unique case (rd_addr[1:0])
                2'b00: rd_data = DATA_W'(MFR_CODE);
                2'b01: rd_data = DATA_W'(DEV_ID);
                2'b10: rd_data = DATA_W'(prot_bit);
                2'b11: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/flashcmd_seq.sv
module flashcmd_seq
    import flashcmd_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 16,
    parameter int          NBLK   = 16,
    parameter logic [15:0] DEV_ID = 16'h00D0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [NBLK-1:0]   blk_prot,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        mode,
    output logic              bypass,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              err
);

    localparam int BLK_W = $clog2(NBLK);

    logic at_first, at_second, is_reset, tgt_prot;

    flashcmd_decode #(.NBLK(NBLK)) u_dec (
        .cmp_addr (wr_addr[CMP_W-1:0]),
        .cmd_byte (wr_data[7:0]),
        .blk_idx  (wr_addr[ADDR_W-1 -: BLK_W]),
        .blk_prot (blk_prot),
        .at_first (at_first),
        .at_second(at_second),
        .is_reset (is_reset),
        .tgt_prot (tgt_prot)
    );

    flashcmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .at_first (at_first),
        .at_second(at_second),
        .is_reset (is_reset),
        .tgt_prot (tgt_prot),
        .mode     (mode),
        .bypass   (bypass),
        .prog_req (prog_req),
        .prog_addr(prog_addr),
        .prog_data(prog_data),
        .err      (err)
    );

    flashcmd_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBLK(NBLK), .DEV_ID(DEV_ID)
    ) u_rdmux (
        .mode      (mode),
        .rd_addr   (rd_addr),
        .array_data(array_data),
        .blk_prot  (blk_prot),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/flashcmd_seq_chk.sv
module flashcmd_seq_chk
    import flashcmd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [7:0]        wr_lo,
    input logic              busy,
    input logic [1:0]        rd_lo,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        mode,
    input logic              prog_req,
    input logic              err
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);                                                   // R1

    AST_MFR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTOSEL && rd_lo == 2'b00) |-> rd_data == DATA_W'(MFR_CODE)); // R3

    AST_PROG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        prog_req |-> ($past(wr_valid) && !$past(busy)));                  // R5

    AST_RESET_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(wr_valid) && $past(wr_lo) == CMD_RESET && $past(mode) != MODE_BYPASS)
        |-> mode == MODE_READ);                                           // R9

    AST_ERR_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(err) |-> !prog_req);                                        // R12

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(wr_valid) && $past(busy) && $past(wr_lo) != CMD_RESET)
        |-> (!prog_req && mode == $past(mode)));                          // R13

endmodule

bind flashcmd_seq flashcmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_lo   (wr_data[7:0]),
    .busy    (busy),
    .rd_lo   (rd_addr[1:0]),
    .rd_data (rd_data),
    .mode    (mode),
    .prog_req(prog_req),
    .err     (err)
);

// File: tb/flashcmd_seq_bench.sv
module flashcmd_seq_bench;

    localparam logic [15:0] DEV = 16'h00D0;
    localparam logic [15:0] ARR = 16'hBEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0;
    logic        busy = 1'b0;
    logic [15:0] blk_prot = 16'h0008;   // block 3 protected
    logic [15:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  mode;
    logic        bypass, prog_req, err;
    logic [15:0] prog_addr, prog_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct packed {
        logic [1:0]  m;
        logic        p;
        logic [15:0] a;
        logic [15:0] d;
        logic        e;
    } exp_t;

    exp_t  q[$];
    string tq[$];

    always #4 clk = ~clk;   // 125 MHz

    flashcmd_seq #(.DEV_ID(DEV)) u_flashcmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .blk_prot(blk_prot), .rd_addr(rd_addr),
        .array_data(ARR), .rd_data(rd_data), .mode(mode), .bypass(bypass),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data), .err(err)
    );

    task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exv);
        n_chk++;
        if (act !== exv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tg, act, exv);
        end
    endtask

    // driver: one write, then push the expected post-write state
    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] em,
                      input logic ep, input logic ee, input string tg);
        exp_t x;
        wr_addr = a; wr_data = d; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        x.m = em; x.p = ep; x.a = a; x.d = d; x.e = ee;
        q.push_back(x);
        tq.push_back(tg);
    endtask

    task automatic idle(input logic [1:0] em, input logic ee, input string tg);
        exp_t x;
        @(negedge clk);
        x.m = em; x.p = 1'b0; x.a = '0; x.d = '0; x.e = ee;
        q.push_back(x);
        tq.push_back(tg);
    endtask

    task automatic rdchk(input logic [15:0] a, input logic [15:0] exv, input string tg);
        rd_addr = a;
        #1;
        chk(tg, rd_data, exv);
    endtask

    task automatic prefix(input logic [1:0] em, input logic ee, input string tg);
        wr(16'h0555, 16'h00AA, 2'd0, 1'b0, ee, tg);
        wr(16'h02AA, 16'h0055, 2'd0, 1'b0, ee, tg);
        if (em != 2'd0) ; // no-op: prefix always ends in read-mode encoding
    endtask

    // monitor: pops one expectation per cycle after a write
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t  x;
            string t;
            x = q.pop_front();
            t = tq.pop_front();
            chk({t, " mode"}, 32'(mode), 32'(x.m));
            chk({t, " bypass"}, 32'(bypass), 32'(x.m == 2'd2));
            chk({t, " prog_req"}, 32'(prog_req), 32'(x.p));
            chk({t, " err"}, 32'(err), 32'(x.e));
            if (x.p) begin
                chk({t, " prog_addr"}, 32'(prog_addr), 32'(x.a));
                chk({t, " prog_data"}, 32'(prog_data), 32'(x.d));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", 32'(mode), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 prog_req", 32'(prog_req), 0);
        chk("R1 bypass", 32'(bypass), 0);
        rdchk(16'h0000, ARR, "R1 array read");

        // R2/R3/R4 auto-select
        prefix(2'd0, 1'b0, "R2 prefix");
        wr(16'h0555, 16'h0090, 2'd1, 1'b0, 1'b0, "R2 enter");
        @(negedge clk);
        rdchk(16'h0000, 16'h0020, "R3 mfr");
        rdchk(16'h0001, DEV, "R3 dev");
        rdchk(16'h0003, 16'h0000, "R3 a11");
        rdchk(16'h3002, 16'h0001, "R4 prot blk3");
        rdchk(16'h5002, 16'h0000, "R4 unprot blk5");
        rdchk(16'hF002, 16'h0000, "R4 unprot blk15");
        idle(2'd1, 1'b0, "R2 sticky");
        wr(16'h1234, 16'h00F0, 2'd0, 1'b0, 1'b0, "R9 single F0");

        // R11 high bits ignored
        wr(16'hF555, 16'h12AA, 2'd0, 1'b0, 1'b0, "R11 aa");
        wr(16'hFAAA, 16'h3455, 2'd0, 1'b0, 1'b0, "R11 55");
        wr(16'h8555, 16'hFF90, 2'd1, 1'b0, 1'b0, "R11 90");
        @(negedge clk);
        rdchk(16'h0000, 16'h0020, "R11 autosel read");
        prefix(2'd0, 1'b0, "R9 prefix");
        wr(16'h0555, 16'h00F0, 2'd0, 1'b0, 1'b0, "R9 three-write F0");
        @(negedge clk);
        rdchk(16'h0000, ARR, "R9 array after reset");

        // R5 program
        prefix(2'd0, 1'b0, "R5 prefix");
        wr(16'h0555, 16'h00A0, 2'd0, 1'b0, 1'b0, "R5 cmd");
        wr(16'h0100, 16'hCAFE, 2'd0, 1'b1, 1'b0, "R5 program");
        idle(2'd0, 1'b0, "R5 single pulse");

        // R10 broken sequences
        wr(16'h0555, 16'h00AA, 2'd0, 1'b0, 1'b0, "R10 aa");
        wr(16'h02AB, 16'h0055, 2'd0, 1'b0, 1'b0, "R10 bad addr");
        wr(16'h0555, 16'h0090, 2'd0, 1'b0, 1'b0, "R10 no autosel");
        prefix(2'd0, 1'b0, "R10 prefix");
        wr(16'h0556, 16'h00A0, 2'd0, 1'b0, 1'b0, "R10 bad cmd addr");
        wr(16'h0100, 16'h1111, 2'd0, 1'b0, 1'b0, "R10 no program");
        prefix(2'd0, 1'b0, "R10 prefix2");
        wr(16'h0555, 16'h0077, 2'd0, 1'b0, 1'b0, "R10 unknown cmd");

        // R12 protected program
        prefix(2'd0, 1'b0, "R12 prefix");
        wr(16'h0555, 16'h00A0, 2'd0, 1'b0, 1'b0, "R12 cmd");
        wr(16'h3010, 16'h1357, 2'd0, 1'b0, 1'b1, "R12 protected");
        idle(2'd0, 1'b1, "R12 sticky");
        wr(16'h0000, 16'h00F0, 2'd0, 1'b0, 1'b0, "R9 clears err");

        // R13 busy
        prefix(2'd0, 1'b0, "R13 prefix");
        wr(16'h0555, 16'h00A0, 2'd0, 1'b0, 1'b0, "R13 cmd");
        busy = 1'b1;
        wr(16'h0100, 16'h2468, 2'd0, 1'b0, 1'b0, "R13 held off");
        busy = 1'b0;
        wr(16'h0104, 16'h9999, 2'd0, 1'b1, 1'b0, "R13 wait kept");
        prefix(2'd0, 1'b0, "R13 prefix2");
        wr(16'h0555, 16'h0090, 2'd1, 1'b0, 1'b0, "R13 autosel");
        busy = 1'b1;
        wr(16'h0555, 16'h00AA, 2'd1, 1'b0, 1'b0, "R13 ignored");
        wr(16'h0000, 16'h00F0, 2'd0, 1'b0, 1'b0, "R9 F0 while busy");
        busy = 1'b0;

        // R6/R7/R8 unlock bypass
        prefix(2'd0, 1'b0, "R6 prefix");
        wr(16'h0555, 16'h0020, 2'd2, 1'b0, 1'b0, "R6 enter");
        wr(16'h0000, 16'h00F0, 2'd2, 1'b0, 1'b0, "R6 F0 ignored");
        wr(16'h0555, 16'h00AA, 2'd2, 1'b0, 1'b0, "R6 AA ignored");
        @(negedge clk);
        rdchk(16'h0000, ARR, "R6 array read");
        wr(16'h7777, 16'h00A0, 2'd2, 1'b0, 1'b0, "R7 cmd");
        wr(16'h0200, 16'h55AA, 2'd2, 1'b1, 1'b0, "R7 program");
        wr(16'h0123, 16'h00A0, 2'd2, 1'b0, 1'b0, "R7 cmd2");
        wr(16'h3020, 16'h4444, 2'd2, 1'b0, 1'b1, "R12 bypass protected");
        wr(16'h0000, 16'h0090, 2'd2, 1'b0, 1'b1, "R8 90");
        wr(16'h0000, 16'h0001, 2'd2, 1'b0, 1'b1, "R8 stays");
        wr(16'h0000, 16'h0090, 2'd2, 1'b0, 1'b1, "R8 90 again");
        wr(16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, "R8 exit");
        wr(16'h0000, 16'h00F0, 2'd0, 1'b0, 1'b0, "R9 final clear");

        idle(2'd0, 1'b0, "R1 end idle");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule